// File: doc/BRIEF.md
# I2C Target Event Flag Unit

This block watches an I2C bus from the target side and turns bus activity into seven sticky event flags and one interrupt request. SCL and SDA are sampled with a faster system clock through two-flop synchronizers. From the synchronized lines the block finds start, repeated start and stop conditions and counts SCL falling edges within each byte, so that each event lands on a defined edge. An edge is the 8th for address and data bytes, and the 9th for the acknowledge slot and the byte count.

The surrounding target logic compares addresses, keeps the byte count and selects the operating mode. It feeds the block with an address-match level, a 10-bit addressing level, a count-is-zero level, a 3-bit mode field and one enable bit per flag. Software reads the flag vector and overwrites it through a single write strobe. Clearing a flag means writing 0 to its bit.

Top module: `i2c_tgt_evflags`

## Requirements
- R1: While reset is asserted and right after it, every flag reads 0 and the interrupt request is low.
- R2: SDA falling while SCL is high sets bit 0 (start) when no transfer is active, or bit 1 (repeated start) when a transfer is active. Either condition begins a new address byte.
- R3: SDA rising while SCL is high sets bit 2 (stop) and ends the transfer.
- R4: Bit 3 (address) sets on the 8th SCL falling edge of an address byte only when the address-match input is high in that cycle. A non-matching address leaves it clear.
- R5: Bit 4 (data write) sets on the 8th SCL falling edge of a data byte only while the block is addressed and the transfer direction taken from the address byte's last bit is write (0). Read transfers and unaddressed transfers never set it.
- R6: Bit 5 (acknowledge time) sets on the 9th SCL falling edge of any byte while the block is addressed. In 10-bit mode a matching high address byte with R/W = 0 does not set it; the following matching low address byte does.
- R7: Bit 6 (byte count) sets on the 9th SCL falling edge when the count-is-zero input is high.
- R8: Bits 3, 4 and 5 can only be set when the mode field is 0xx or 11x. For modes 100 and 101 they stay clear.
- R9: A software write loads the whole flag vector from the write data. A hardware set in the same cycle wins over a written 0.
- R10: The interrupt request is high exactly when some flag is 1 and its enable bit is 1.
- R11: A start or repeated start restarts the SCL edge count, so the SCL fall that ends the condition is not counted. The count wraps after the 9th edge. A flag appears three clock cycles after the pin change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| addr_match_i | input | 1 | Current address byte matches this target |
| ten_bit_i | input | 1 | 10-bit addressing selected |
| cnt_zero_i | input | 1 | External byte count is zero |
| mode_i | input | 3 | Operating mode field |
| flag_en_i | input | 7 | Per-flag interrupt enables |
| sw_we_i | input | 1 | Software write strobe for the flag vector |
| sw_wdata_i | input | 7 | Software write data |
| flags_o | output | 7 | Flag vector: 6 count, 5 ack time, 4 write, 3 address, 2 stop, 1 restart, 0 start |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions assume that the match, 10-bit, count-zero and mode levels are stable around each 8th and 9th SCL falling edge. They also assume that a flag rising without a software write can be traced to the input sampled in the cycle before. The stimulus changes these levels only between bytes, and it changes SDA only while SCL is low, except for deliberate start, repeated start and stop conditions. Each bus phase is held for four system clocks, so every edge passes cleanly through the synchronizers.

// File: rtl/i2c_evf_pkg.sv
package i2c_evf_pkg;

    localparam int NFLAG    = 7;
    localparam int MODE_W   = 3;

    localparam int F_START  = 0;
    localparam int F_RSTART = 1;
    localparam int F_STOP   = 2;
    localparam int F_ADR    = 3;
    localparam int F_WR     = 4;
    localparam int F_ACKT   = 5;
    localparam int F_CNT    = 6;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ADDR    = 2'd1,
        PH_ADDR_LO = 2'd2,
        PH_DATA    = 2'd3
    } phase_e;

    // Address, write and ack-time events are live for modes 0xx and 11x.
    function automatic logic mode_gate(input logic [MODE_W-1:0] m);
        return (m[MODE_W-1] == 1'b0) || (m[MODE_W-1:MODE_W-2] == 2'b11);
    endfunction

endpackage

// File: rtl/i2c_evf_sync.sv
module i2c_evf_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_evf_bus.sv
module i2c_evf_bus #(
    parameter int BIT_EDGES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic start_o,
    output logic rstart_o,
    output logic stop_o,
    output logic data_edge_o,
    output logic ack_edge_o,
    output logic rw_o
);
    localparam int CW = $clog2(BIT_EDGES + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(BIT_EDGES);
    localparam logic [CW-1:0] DATA_PRE = CW'(BIT_EDGES - 2);
    localparam logic [CW-1:0] ACK_PRE  = CW'(BIT_EDGES - 1);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic          active;
        logic          rise_seen;
        logic          rw;
        logic [CW-1:0] cnt;
    } bus_st_t;

    bus_st_t cur_q, nxt_d;
    logic scl_rise, scl_fall, sda_fall, sda_rise, counted_fall;

    always_comb begin
        nxt_d        = cur_q;
        scl_rise     = scl_s_i && !cur_q.scl_p;
        scl_fall     = !scl_s_i && cur_q.scl_p;
        sda_fall     = !sda_s_i && cur_q.sda_p && scl_s_i && cur_q.scl_p;
        sda_rise     = sda_s_i && !cur_q.sda_p && scl_s_i && cur_q.scl_p;
        counted_fall = scl_fall && cur_q.active && cur_q.rise_seen;

        start_o     = sda_fall && !cur_q.active;
        rstart_o    = sda_fall && cur_q.active;
        stop_o      = sda_rise;
        data_edge_o = counted_fall && (cur_q.cnt == DATA_PRE);
        ack_edge_o  = counted_fall && (cur_q.cnt == ACK_PRE);
        rw_o        = cur_q.rw;

        nxt_d.scl_p = scl_s_i;
        nxt_d.sda_p = sda_s_i;
        if (scl_rise) begin
            nxt_d.rise_seen = 1'b1;
            nxt_d.rw        = sda_s_i;
        end
        if (counted_fall) begin
            nxt_d.cnt = (cur_q.cnt == LAST_CNT) ? CW'(1) : cur_q.cnt + CW'(1);
        end
        if (sda_fall || sda_rise) begin
            nxt_d.cnt       = '0;
            nxt_d.rise_seen = 1'b0;
            nxt_d.active    = sda_fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.scl_p <= 1'b1;
            cur_q.sda_p <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/i2c_tgt_evflags.sv
module i2c_tgt_evflags
    import i2c_evf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int BIT_EDGES   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_match_i,
    input  logic              ten_bit_i,
    input  logic              cnt_zero_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [NFLAG-1:0]  flag_en_i,
    input  logic              sw_we_i,
    input  logic [NFLAG-1:0]  sw_wdata_i,
    output logic [NFLAG-1:0]  flags_o,
    output logic              irq_o
);
    typedef struct packed {
        phase_e           phase;
        logic             addressed;
        logic             dir;
        logic [NFLAG-1:0] flags;
    } top_st_t;

    logic [1:0] lines_s;
    logic ev_start, ev_rstart, ev_stop, ev_d8, ev_d9, ev_rw, gate;
    logic [NFLAG-1:0] set_v;
    top_st_t cur_q, nxt_d;

    i2c_evf_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (lines_s)
    );

    i2c_evf_bus #(.BIT_EDGES(BIT_EDGES)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s_i     (lines_s[1]),
        .sda_s_i     (lines_s[0]),
        .start_o     (ev_start),
        .rstart_o    (ev_rstart),
        .stop_o      (ev_stop),
        .data_edge_o (ev_d8),
        .ack_edge_o  (ev_d9),
        .rw_o        (ev_rw)
    );

    always_comb begin
        nxt_d           = cur_q;
        gate            = mode_gate(mode_i);
        set_v           = '0;
        set_v[F_START]  = ev_start;
        set_v[F_RSTART] = ev_rstart;
        set_v[F_STOP]   = ev_stop;

        if (ev_start || ev_rstart) begin
            nxt_d.phase     = PH_ADDR;
            nxt_d.addressed = 1'b0;
        end else if (ev_stop) begin
            nxt_d.phase     = PH_IDLE;
            nxt_d.addressed = 1'b0;
        end else if (ev_d8) begin
            case (cur_q.phase)
                PH_ADDR: begin
                    set_v[F_ADR] = addr_match_i && gate;
                    nxt_d.dir    = ev_rw;
                    // matching 10-bit high byte for a write waits for the low byte
                    if (ten_bit_i && addr_match_i && !ev_rw) begin
                        nxt_d.phase     = PH_ADDR_LO;
                        nxt_d.addressed = 1'b0;
                    end else begin
                        nxt_d.phase     = PH_DATA;
                        nxt_d.addressed = addr_match_i;
                    end
                end
                PH_ADDR_LO: begin
                    set_v[F_ADR]    = addr_match_i && gate;
                    nxt_d.addressed = addr_match_i;
                    nxt_d.phase     = PH_DATA;
                end
                PH_DATA: begin
                    set_v[F_WR] = cur_q.addressed && !cur_q.dir && gate;
                end
                default: begin
                end
            endcase
        end else if (ev_d9) begin
            set_v[F_ACKT] = cur_q.addressed && gate;
            set_v[F_CNT]  = cnt_zero_i;
        end

        nxt_d.flags = (sw_we_i ? sw_wdata_i : cur_q.flags) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.phase <= PH_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flags_o = cur_q.flags;
    assign irq_o   = |(cur_q.flags & flag_en_i);
endmodule

// File: rtl/i2c_evf_chk.sv
module i2c_evf_chk
    import i2c_evf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr_match_i,
    input logic              cnt_zero_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              sw_we_i,
    input logic [NFLAG-1:0]  flags_o
);
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (flags_o == '0)
                else $error("R1 flags not clear in reset");
        end
    end

    a_r4_adr_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[F_ADR]) |-> ($past(addr_match_i) || $past(sw_we_i)))
        else $error("R4 address flag without match");

    a_r7_cnt_needs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[F_CNT]) |-> ($past(cnt_zero_i) || $past(sw_we_i)))
        else $error("R7 count flag without zero count");

    a_r8_mode_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_gate(mode_i) && !sw_we_i) |=>
            ((flags_o & ~$past(flags_o)) & NFLAG'(7'h38)) == '0)
        else $error("R8 gated flag set in closed mode");

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_we_i |=> (($past(flags_o) & ~flags_o) == '0))
        else $error("R9 flag cleared without write");
endmodule

bind i2c_tgt_evflags i2c_evf_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_match_i (addr_match_i),
    .cnt_zero_i   (cnt_zero_i),
    .mode_i       (mode_i),
    .sw_we_i      (sw_we_i),
    .flags_o      (flags_o)
);

// File: tb/sim_i2c_tgt_evflags.sv
module sim_i2c_tgt_evflags;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl = 1'b1, sda = 1'b1, match = 1'b0, ten = 1'b0, czero = 1'b0, we = 1'b0;
    logic [2:0] mode = 3'b000;
    logic [6:0] en = 7'h00, wdata = 7'h00;
    logic [6:0] flags;
    logic irq;

    int n_run = 0, n_fail = 0;
    string cur_req = "R1";
    bit watch = 0, seen_adr = 0, done = 0;

    i2c_tgt_evflags u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .addr_match_i(match), .ten_bit_i(ten), .cnt_zero_i(czero),
        .mode_i(mode), .flag_en_i(en), .sw_we_i(we), .sw_wdata_i(wdata),
        .flags_o(flags), .irq_o(irq)
    );

    // behavioural reference: pin delay line plus event rules
    logic s1c, s2c, pc, s1d, s2d, pd;
    int   mcnt, mph;
    bit   mrise, mact, mrw, maddr, mdir;
    logic [6:0] mfl;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1c = 1; s2c = 1; pc = 1; s1d = 1; s2d = 1; pd = 1;
            mcnt = 0; mph = 0; mrise = 0; mact = 0; mrw = 0; maddr = 0; mdir = 0; mfl = 0;
        end else begin
            bit rise, fall, sf, sr, f8, f9, ok;
            logic [6:0] st;
            rise = s2c && !pc;
            fall = !s2c && pc;
            sf   = !s2d && pd && s2c && pc;
            sr   = s2d && !pd && s2c && pc;
            f8   = fall && mact && mrise && (mcnt == 7);
            f9   = fall && mact && mrise && (mcnt == 8);
            ok   = (mode[2] == 1'b0) || (mode[2:1] == 2'b11);
            st   = 0;
            st[0] = sf && !mact;
            st[1] = sf && mact;
            st[2] = sr;
            if (sf) begin mph = 1; maddr = 0; end
            else if (sr) begin mph = 0; maddr = 0; end
            else if (f8) begin
                if (mph == 1) begin
                    st[3] = match && ok;
                    mdir = mrw;
                    if (ten && match && !mrw) begin mph = 2; maddr = 0; end
                    else begin mph = 3; maddr = match; end
                end else if (mph == 2) begin
                    st[3] = match && ok;
                    maddr = match;
                    mph = 3;
                end else if (mph == 3) begin
                    st[4] = maddr && !mdir && ok;
                end
            end else if (f9) begin
                st[5] = maddr && ok;
                st[6] = czero;
            end
            if (sf || sr) begin
                mcnt = 0; mrise = 0; mact = sf;
            end else begin
                if (rise) begin mrise = 1; mrw = s2d; end
                if (fall && mact && mrise) mcnt = (mcnt == 9) ? 1 : mcnt + 1;
            end
            mfl = (we ? wdata : mfl) | st;
            pc = s2c; s2c = s1c; s1c = scl;
            pd = s2d; s2d = s1d; s1d = sda;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            n_run++;
            if (flags !== mfl || irq !== |(mfl & en)) begin
                n_fail++;
                $display("FAIL %s per-cycle model: actual flags=%h irq=%b expected flags=%h irq=%b",
                         cur_req, flags, irq, mfl, |(mfl & en));
            end
            if (watch && flags[3]) seen_adr = 1;
        end
    end

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hold();
        repeat (4) @(negedge clk);
    endtask
    task automatic b_start();
        sda = 1; scl = 1; hold(); sda = 0; hold(); scl = 0; hold();
    endtask
    task automatic b_rstart();
        sda = 1; hold(); scl = 1; hold(); sda = 0; hold(); scl = 0; hold();
    endtask
    task automatic b_stop();
        sda = 0; hold(); scl = 1; hold(); sda = 1; hold();
    endtask
    task automatic b_bit(input logic b);
        sda = b; hold(); scl = 1; hold(); scl = 0; hold();
    endtask
    task automatic b_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) b_bit(v[i]);
        b_bit(1'b0);
    endtask
    task automatic sw_clear();
        we = 1; wdata = 0; @(negedge clk); we = 0; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flags, 7'h00);
        chk("R1 reset irq", {6'd0, irq}, 7'h00);
        rst_n = 1;
        hold();
        chk("R1 after reset", flags, 7'h00);

        // 7-bit write, matching
        cur_req = "R4"; match = 1;
        b_start();
        chk("R2 start flag", flags, 7'h01);
        for (int i = 7; i >= 0; i--) b_bit(i == 0 ? 1'b0 : 1'(8'hA4 >> i));
        chk("R4 R11 address on 8th fall, ack not yet", flags, 7'h09);
        b_bit(1'b0);
        chk("R6 ack time on 9th fall", flags, 7'h29);
        sw_clear();
        chk("R9 write zero clears", flags, 7'h00);
        cur_req = "R5";
        b_byte(8'h55);
        chk("R5 data write flag", flags, 7'h30);
        sw_clear();
        cur_req = "R7"; czero = 1;
        b_byte(8'hC3);
        chk("R7 count zero flag", flags, 7'h70);
        czero = 0; sw_clear();
        cur_req = "R3";
        b_stop();
        chk("R3 stop flag", flags, 7'h04);
        sw_clear();

        // non-matching address
        cur_req = "R4"; match = 0;
        b_start(); b_byte(8'hA4);
        chk("R4 no address flag on mismatch", flags, 7'h01);
        b_byte(8'h12);
        chk("R5 R6 unaddressed data byte", flags, 7'h01);
        b_stop(); sw_clear();

        // read direction
        cur_req = "R5"; match = 1;
        b_start(); b_byte(8'hA5);
        chk("R6 read address acked", flags, 7'h29);
        sw_clear();
        b_byte(8'h3C);
        chk("R5 read data gives no write flag", flags, 7'h20);
        b_stop(); sw_clear();

        // 10-bit addressing
        cur_req = "R6"; ten = 1;
        b_start(); b_byte(8'hF0);
        chk("R6 10-bit high byte write: no ack time", flags, 7'h09);
        sw_clear();
        b_byte(8'h33);
        chk("R6 10-bit low byte sets ack time", flags, 7'h28);
        sw_clear();
        b_byte(8'h99);
        chk("R5 10-bit data write", flags, 7'h30);
        sw_clear();
        cur_req = "R2";
        b_rstart();
        chk("R2 repeated start flag", flags, 7'h02);
        b_byte(8'hF1);
        chk("R6 10-bit high byte read acked", flags, 7'h2A);
        b_stop(); sw_clear(); ten = 0;

        // mode gating
        cur_req = "R8"; mode = 3'b100;
        b_start(); b_byte(8'hA4); b_byte(8'h55);
        chk("R8 mode 100 keeps gated flags clear", flags, 7'h01);
        b_stop(); sw_clear();
        mode = 3'b101;
        b_start(); b_byte(8'hA4);
        chk("R8 mode 101 keeps gated flags clear", flags, 7'h01);
        b_stop(); sw_clear();
        mode = 3'b110;
        b_start(); b_byte(8'hA4);
        chk("R8 mode 110 open", flags, 7'h29);
        b_stop(); sw_clear(); mode = 3'b000;

        // counter restart on repeated start
        cur_req = "R11";
        b_start();
        for (int i = 0; i < 4; i++) b_bit(1'b1);
        b_rstart();
        for (int i = 0; i < 8; i++) b_bit(1'b0);
        chk("R11 count restarts after repeated start", flags, 7'h0B);
        b_bit(1'b0);
        chk("R11 ack after restart", flags, 7'h2B);
        b_stop(); sw_clear();

        // set beats a simultaneous zero write
        cur_req = "R9";
        b_start();
        we = 1; wdata = 0; watch = 1;
        b_byte(8'hA4);
        we = 0; watch = 0;
        @(negedge clk);
        chk("R9 hardware set wins over write 0", {6'd0, seen_adr}, 7'h01);
        b_stop(); sw_clear();
        we = 1; wdata = 7'h40; @(negedge clk); we = 0; @(negedge clk);
        chk("R9 write loads value", flags, 7'h40);

        // interrupt combine
        cur_req = "R10";
        en = 7'h00; @(negedge clk);
        chk("R10 irq low with no enables", {6'd0, irq}, 7'h00);
        en = 7'h3F; @(negedge clk);
        chk("R10 irq low when set flag disabled", {6'd0, irq}, 7'h00);
        en = 7'h40; @(negedge clk);
        chk("R10 irq high for enabled set flag", {6'd0, irq}, 7'h01);
        sw_clear();
        chk("R10 irq low after clear", {6'd0, irq}, 7'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_run++;
            n_fail++;
            $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule